// File: doc/BRIEF.md
# Scaled-Index Shift-and-Add Unit

This execution unit forms a scaled-index sum from two operands: a base value and an index value. The index is first conditioned according to the selected operation. It can be taken at full width, or its low half-word can be sign-extended or zero-extended. The conditioned index is then shifted left by one more than a 2-bit scale field, so it is multiplied by 2, 4, 8 or 16. The shifted index is added to the base. The sum wraps modulo 2^W, and nothing is reported for bits lost from the top.

The unit is meant for array address arithmetic and general scaled arithmetic in an integer pipeline. A caller may also ask for a signed three-way comparison of the result against zero. The result and its condition summary appear either combinationally or after one register stage, chosen by a parameter. The default is one register stage. An operation code outside the three defined ones gives a zero result and raises an illegal flag.

Top module: `scidx_alu`

## Requirements
- R1: The index is shifted left by `scale_i + 1` bits, giving multipliers 2, 4, 8 and 16 for `scale_i` values 0, 1, 2 and 3.
- R2: With `op_i` = 2'b00 (full width), `result_o` = (`index_i` << (`scale_i`+1)) + `base_i`, with all W bits of the index used as an unsigned value.
- R3: With `op_i` = 2'b01 (signed low word), bits W-1..W/2 of `index_i` are ignored. Bit W/2-1 is replicated into the upper half before the shift and add.
- R4: With `op_i` = 2'b10 (unsigned low word), bits W-1..W/2 of `index_i` are ignored. The upper half is filled with zeros before the shift and add.
- R5: The sum wraps modulo 2^W. Index bits shifted above bit W-1 and any carry out of the adder are discarded.
- R6: When `rec_i` is 1, `cond_o` is one-hot and reads the result as signed: bit 2 set means negative, bit 1 set means positive, bit 0 set means zero.
- R7: When `rec_i` is 0, `cond_o` is 3'b000 whatever the result.
- R8: With `op_i` = 2'b11 (reserved), `result_o` is zero and `illegal_o` is 1. For every other code `illegal_o` is 0. The zero result still produces a condition summary, so `cond_o` reads 3'b001 when `rec_i` is 1.
- R9: With `REG_OUT` = 1, the outputs show the inputs sampled at the previous rising clock edge. A clock edge with `rst_n` low clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous reset, active low |
| base_i | input | 64 | Base operand added to the scaled index |
| index_i | input | 64 | Index operand |
| scale_i | input | 2 | Scale field; the shift amount is this value plus one |
| op_i | input | 2 | 00 full width, 01 signed low word, 10 unsigned low word, 11 reserved |
| rec_i | input | 1 | Requests the condition summary |
| result_o | output | 64 | Wrapped scaled-index sum |
| cond_o | output | 3 | {negative, positive, zero} summary of the result, or zero |
| illegal_o | output | 1 | Set when a reserved operation code was given |

## Verification
The hardest cases to reach from the ports are the word modes. There the upper half of the index must have no effect, and the outcome depends only on bit 31 of the low word. Random 64-bit operands almost never place the low word on that sign boundary. The stimulus therefore forces the low words 0x7FFFFFFF, 0x80000000, 0xFFFFFFFF and 0x00000000 under random upper halves, in all three modes and at every scale value. It also adds directed vectors whose sums wrap exactly to zero, so that the zero and negative summaries occur in a controlled way.

// File: rtl/scidx_pkg.sv
// Package: shared operation codes for the scaled-index shift-and-add unit.
// Assumes a 2-bit operation select; the fourth code is reserved.
package scidx_pkg;
    typedef enum logic [1:0] {
        OP_FULL  = 2'b00,
        OP_SWORD = 2'b01,
        OP_UWORD = 2'b10,
        OP_RSVD  = 2'b11
    } scidx_op_e;

    localparam int COND_W = 3;
endpackage

// File: rtl/scidx_index_prep.sv
// Module: scidx_index_prep
// Conditions the index operand for the selected operation. It passes the
// index through at full width, sign-extends the low half, or zero-extends
// the low half. A reserved code yields zero and flags the operation as
// illegal. Assumes W is even.
module scidx_index_prep
    import scidx_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] idx_i,
    input  logic [1:0]   op_i,
    output logic [W-1:0] idx_o,
    output logic         illegal_o
);
    localparam int HALF = W / 2;

    scidx_op_e op;
    assign op = scidx_op_e'(op_i);

    // Purpose: choose the extension applied to the index operand.
    always_comb begin
        idx_o     = '0;
        illegal_o = 1'b0;
        unique case (op)
            OP_FULL:  idx_o = idx_i;
            OP_SWORD: idx_o = {{HALF{idx_i[HALF-1]}}, idx_i[HALF-1:0]};
            OP_UWORD: idx_o = {{HALF{1'b0}}, idx_i[HALF-1:0]};
            default:  illegal_o = 1'b1;
        endcase
    end

    // Purpose: check the upper half against the mode contract.
    always_comb begin
        if (op == OP_UWORD)
            a_r4_upper_zero: assert (idx_o[W-1:HALF] == '0);
        if (op == OP_SWORD)
            a_r3_sign_fill: assert (idx_o[W-1:HALF] == {HALF{idx_i[HALF-1]}});
        if (op == OP_RSVD)
            a_r8_rsvd_zero: assert (idx_o == '0 && illegal_o);
    end
endmodule

// File: rtl/scidx_scale_add.sv
// Module: scidx_scale_add
// Shifts the conditioned index left by (scale + 1) bits and adds the base.
// The sum wraps modulo 2^W. One candidate shift is built per scale code,
// and the scale field selects among them.
module scidx_scale_add #(
    parameter int W   = 64,
    parameter int SHW = 2
) (
    input  logic [W-1:0]   base_i,
    input  logic [W-1:0]   idx_i,
    input  logic [SHW-1:0] scale_i,
    output logic [W-1:0]   sum_o
);
    localparam int NSH = 1 << SHW;

    logic [W-1:0] shifted [NSH];
    logic [W-1:0] pick;

    // Purpose: fixed-distance shifters, one for each scale code.
    for (genvar s = 0; s < NSH; s++) begin : g_shift
        assign shifted[s] = idx_i << (s + 1);
    end

    // Purpose: select the shifter named by the scale field and add the base.
    always_comb begin
        pick  = shifted[scale_i];
        sum_o = pick + base_i;
    end

    // Purpose: the low (scale + 1) bits of the shifted index are always zero.
    always_comb begin
        a_r1_low_zero: assert ((pick & ((W'(1) << (scale_i + 1)) - W'(1))) == '0);
    end
endmodule

// File: rtl/scidx_cond.sv
// Module: scidx_cond
// Produces the signed comparison of a value against zero as
// {negative, positive, zero}, and gates it with the record request.
module scidx_cond
    import scidx_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0]      val_i,
    input  logic              rec_i,
    output logic [COND_W-1:0] cond_o
);
    logic neg, zer;

    // Purpose: classify the value and apply the record gate.
    always_comb begin
        neg    = val_i[W-1];
        zer    = (val_i == '0);
        cond_o = rec_i ? {neg, !neg && !zer, zer} : '0;
    end
endmodule

// File: rtl/scidx_alu.sv
// Module: scidx_alu (top)
// Scaled-index shift-and-add unit. With REG_OUT = 1, one output register
// stage is cleared by the synchronous active-low reset. With REG_OUT = 0,
// the outputs are combinational and rst_n is unused.
module scidx_alu
    import scidx_pkg::*;
#(
    parameter int W       = 64,
    parameter int SHW     = 2,
    parameter bit REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [63:0]   base_i,
    input  logic [63:0]   index_i,
    input  logic [1:0]    scale_i,
    input  logic [1:0]    op_i,
    input  logic          rec_i,
    output logic [63:0]   result_o,
    output logic [2:0]    cond_o,
    output logic          illegal_o
);
    logic [W-1:0]      idx_c;
    logic              ill_c;
    logic [W-1:0]      sum_c;
    logic [W-1:0]      res_c;
    logic [COND_W-1:0] cond_c;

    scidx_index_prep #(.W(W)) i_prep (
        .idx_i     (index_i),
        .op_i      (op_i),
        .idx_o     (idx_c),
        .illegal_o (ill_c)
    );

    scidx_scale_add #(.W(W), .SHW(SHW)) i_sadd (
        .base_i  (base_i),
        .idx_i   (idx_c),
        .scale_i (scale_i),
        .sum_o   (sum_c)
    );

    // Purpose: force a zero result for the reserved operation code.
    always_comb res_c = ill_c ? '0 : sum_c;

    scidx_cond #(.W(W)) i_cond (
        .val_i  (res_c),
        .rec_i  (rec_i),
        .cond_o (cond_c)
    );

    if (REG_OUT) begin : g_reg
        // Purpose: one-cycle output stage with synchronous clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                result_o  <= '0;
                cond_o    <= '0;
                illegal_o <= 1'b0;
            end else begin
                result_o  <= res_c;
                cond_o    <= cond_c;
                illegal_o <= ill_c;
            end
        end

        a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (result_o == $past(res_c)) && (cond_o == $past(cond_c)));
        a_r9_reset_clear: assert property (@(posedge clk)
            !rst_n |=> (result_o == '0) && (cond_o == '0) && !illegal_o);
        a_r6_cond_onehot: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(cond_o));
        a_r8_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
            illegal_o |-> (result_o == '0));
    end else begin : g_comb
        // Purpose: direct combinational outputs.
        always_comb begin
            result_o  = res_c;
            cond_o    = cond_c;
            illegal_o = ill_c;
        end
    end
endmodule

// File: tb/test_scidx_alu.sv
module test_scidx_alu;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 13;
    localparam int NRAND = 400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] base_i = '0, index_i = '0;
    logic [1:0]  scale_i = '0, op_i = '0;
    logic        rec_i = 1'b0;
    logic [63:0] result_o;
    logic [2:0]  cond_o;
    logic        illegal_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scidx_alu i_scidx_alu (
        .clk(clk), .rst_n(rst_n), .base_i(base_i), .index_i(index_i),
        .scale_i(scale_i), .op_i(op_i), .rec_i(rec_i),
        .result_o(result_o), .cond_o(cond_o), .illegal_o(illegal_o)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [1:0]  sh;
        logic        rec;
        logic [63:0] base;
        logic [63:0] idx;
        logic [63:0] res;
        logic [2:0]  cond;
        logic        ill;
    } vec_t;

    // Hand-computed vectors: op, scale, rec, base, index, result, cond, illegal
    localparam vec_t VECS [NVEC] = '{
        '{2'b00, 2'd3, 1'b1, 64'h100, 64'h2, 64'h120, 3'b010, 1'b0},
        '{2'b00, 2'd0, 1'b1, 64'h0, 64'h5, 64'hA, 3'b010, 1'b0},
        '{2'b00, 2'd1, 1'b0, 64'h1, 64'h3, 64'hD, 3'b000, 1'b0},
        '{2'b00, 2'd0, 1'b1, 64'h0, 64'hF000_0000_0000_0001, 64'hE000_0000_0000_0002, 3'b100, 1'b0},
        '{2'b00, 2'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE, 64'h1, 64'h0, 3'b001, 1'b0},
        '{2'b01, 2'd0, 1'b1, 64'h0, 64'h1234_5678_8000_0000, 64'hFFFF_FFFF_0000_0000, 3'b100, 1'b0},
        '{2'b01, 2'd3, 1'b1, 64'h1000, 64'hAAAA_AAAA_7FFF_FFFF, 64'h8_0000_0FF0, 3'b010, 1'b0},
        '{2'b01, 2'd1, 1'b1, 64'h40, 64'h0000_0000_FFFF_FFF0, 64'h0, 3'b001, 1'b0},
        '{2'b10, 2'd0, 1'b1, 64'h0, 64'hFFFF_FFFF_8000_0000, 64'h1_0000_0000, 3'b010, 1'b0},
        '{2'b10, 2'd3, 1'b1, 64'h5, 64'h5555_5555_FFFF_FFFF, 64'hF_FFFF_FFF5, 3'b010, 1'b0},
        '{2'b10, 2'd2, 1'b0, 64'h10, 64'hDEAD_BEEF_0000_0001, 64'h18, 3'b000, 1'b0},
        '{2'b11, 2'd1, 1'b1, 64'h55, 64'h7, 64'h0, 3'b001, 1'b1},
        '{2'b11, 2'd2, 1'b0, 64'h99, 64'h3, 64'h0, 3'b000, 1'b1}
    };

    // Reference model written from the requirements.
    function automatic logic [63:0] ref_res(input logic [1:0] op, input logic [1:0] sh,
                                            input logic [63:0] b, input logic [63:0] x);
        logic [63:0] n;
        case (op)
            2'b00: n = x;
            2'b01: n = 64'($signed(x[31:0]));
            2'b10: n = 64'(x[31:0]);
            default: return 64'h0;
        endcase
        return (n * (64'd1 << (sh + 1))) + b;
    endfunction

    function automatic logic [2:0] ref_cond(input logic rec, input logic [63:0] r);
        if (!rec) return 3'b000;
        if ($signed(r) < 0) return 3'b100;
        if (r == 0) return 3'b001;
        return 3'b010;
    endfunction

    task automatic check(input string req, input logic [63:0] er, input logic [2:0] ec,
                         input logic ei);
        total++;
        if (result_o !== er || cond_o !== ec || illegal_o !== ei) begin
            bad++;
            $display("FAIL %s: got res=%h cond=%b ill=%b, expected res=%h cond=%b ill=%b",
                     req, result_o, cond_o, illegal_o, er, ec, ei);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic [1:0] sh, input logic rec,
                         input logic [63:0] b, input logic [63:0] x);
        @(negedge clk);
        op_i = op; scale_i = sh; rec_i = rec; base_i = b; index_i = x;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] r;
        // R9: reset clears outputs even with live inputs
        op_i = 2'b11; rec_i = 1'b1; base_i = 64'h1234; index_i = 64'h5;
        repeat (3) @(negedge clk);
        check("R9 reset", 64'h0, 3'b000, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: R1 R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NVEC; i++) begin
            drive(VECS[i].op, VECS[i].sh, VECS[i].rec, VECS[i].base, VECS[i].idx);
            check($sformatf("R1-table vec %0d (R2/R3/R4/R5/R6/R7/R8)", i),
                  VECS[i].res, VECS[i].cond, VECS[i].ill);
        end

        // R9: one-cycle latency, output holds until the next edge
        drive(2'b00, 2'd0, 1'b1, 64'h0, 64'h4);
        op_i = 2'b00; scale_i = 2'd3; base_i = 64'h1; index_i = 64'h1;
        #1;
        check("R9 hold before edge", 64'h8, 3'b010, 1'b0);
        @(negedge clk);
        check("R9 after edge", 64'h11, 3'b010, 1'b0);

        // R3/R4: sign-boundary low words under random upper halves, all scales
        for (int m = 0; m < 3; m++) begin
            for (int s = 0; s < 4; s++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [31:0] lw;
                    logic [63:0] b, x;
                    lw = (k == 0) ? 32'h7FFF_FFFF : (k == 1) ? 32'h8000_0000 :
                         (k == 2) ? 32'hFFFF_FFFF : 32'h0;
                    x = {$urandom(), lw};
                    b = {$urandom(), $urandom()};
                    drive(m[1:0], s[1:0], 1'b1, b, x);
                    r = ref_res(m[1:0], s[1:0], b, x);
                    check("R3_R4 boundary", r, ref_cond(1'b1, r), 1'b0);
                end
            end
        end

        // R2 R5 R6 R7 R8: random operands
        for (int i = 0; i < NRAND; i++) begin
            logic [1:0] op, sh;
            logic rec;
            logic [63:0] b, x;
            op = 2'($urandom_range(0, 3));
            sh = 2'($urandom_range(0, 3));
            rec = 1'($urandom_range(0, 1));
            b = {$urandom(), $urandom()};
            x = {$urandom(), $urandom()};
            drive(op, sh, rec, b, x);
            r = ref_res(op, sh, b, x);
            check("R2_R5_R6_R7_R8 random", r, ref_cond(rec, r), op == 2'b11);
        end

        // R9: reset mid-run clears registered outputs
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset mid-run", 64'h0, 3'b000, 1'b0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule